// File: doc/BRIEF.md
# Streaming Opcode Byte Decoder

This block takes a stream of machine-code bytes, one byte per valid/ready handshake. For every complete instruction it produces one decoded record. A record gives the operation kind, a 3-bit register selector, a 16-bit target address and the instruction's length in bytes. A downstream unit can use the length to advance its program counter.

Single-byte instructions (no-op, increment, decrement) produce a record straight away. The two jump opcodes first gather a low address byte and then a high address byte before their record is released. The block pulls the register selector out of opcode bits [5:3] rather than looking it up in a table.

An opcode outside the supported set gives a one-cycle error pulse and exposes the offending byte. The decoder then keeps waiting for an opcode. The output side uses a valid/ready handshake. While a record waits to be accepted, the decoder takes no further input.

Top module: `opcode_stream_decoder`

## Requirements
- R1: After a synchronous reset, out_valid and err_pulse are 0 and in_ready is 1. Reset also discards a partly gathered jump, so the next byte is decoded as an opcode.
- R2: Byte 0x00 yields a record with out_kind=0 (no-op), out_len=1, out_reg=0 and out_addr=0.
- R3: A byte of the form 00rrr100 yields out_kind=1 (increment), out_reg=rrr and out_len=1. The selector codes are B=000, C=001, D=010, E=011, H=100, L=101, memory-at-HL=110, A=111.
- R4: A byte of the form 00rrr101 yields out_kind=2 (decrement), out_reg=rrr and out_len=1.
- R5: Byte 0xC3 followed by bytes lo and hi yields out_kind=4 (unconditional jump), out_addr={hi,lo}, out_len=3 and out_reg=0.
- R6: Byte 0xC2 followed by bytes lo and hi yields out_kind=3 (jump if zero flag clear), out_addr={hi,lo} and out_len=3.
- R7: A record becomes valid in the cycle after the handshake of its last byte. A jump's first two bytes produce no record.
- R8: Any other opcode gives err_pulse=1 for the one cycle after it is accepted, with err_opcode equal to that byte. It produces no record, and the next byte is treated as an opcode.
- R9: While out_valid=1 and out_ready=0, the record stays unchanged and in_ready is 0. The record clears in the cycle after out_ready is sampled at 1.
- R10: The two address bytes of a jump are never decoded as opcodes, whatever their value. They raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte is offered |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Decoder can take a byte |
| out_valid | output | 1 | Decoded record is pending |
| out_ready | input | 1 | Consumer accepts the record |
| out_kind | output | 3 | Operation kind code |
| out_reg | output | 3 | Register selector |
| out_addr | output | 16 | Jump target address |
| out_len | output | 2 | Instruction length in bytes (1 or 3) |
| err_pulse | output | 1 | Unsupported opcode seen |
| err_opcode | output | 8 | Last unsupported opcode |

## Verification
Several properties are checked on every cycle. A held record stays stable under backpressure, and a record appears only after an accepted byte. Length and kind always agree, and an error comes only from a byte taken in the opcode state. The bench's scenarios are needed to show the actual decoding: the selector drawn from bits [5:3], the low-then-high byte order of the target, address bytes that look like bad opcodes, and the discarding of a half-gathered jump by reset.

// File: rtl/opdec_pkg.sv
package opdec_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2 * BYTE_W;

    typedef enum logic [2:0] {
        KIND_NOP  = 3'd0,
        KIND_INC  = 3'd1,
        KIND_DEC  = 3'd2,
        KIND_JPNZ = 3'd3,
        KIND_JP   = 3'd4
    } op_kind_e;

    typedef enum logic [1:0] {
        ST_OPCODE = 2'd0,
        ST_LOW    = 2'd1,
        ST_HIGH   = 2'd2
    } dec_state_e;

    typedef struct packed {
        op_kind_e          kind;
        logic [2:0]        sel;
        logic [ADDR_W-1:0] addr;
        logic [1:0]        len;
    } op_rec_t;

    localparam logic [BYTE_W-1:0] OPC_NOP  = 8'h00;
    localparam logic [BYTE_W-1:0] OPC_JP   = 8'hC3;
    localparam logic [BYTE_W-1:0] OPC_JPNZ = 8'hC2;
endpackage

// File: rtl/opdec_classify.sv
module opdec_classify
    import opdec_pkg::*;
(
    input  logic [BYTE_W-1:0] opcode,
    output logic              known,
    output logic              is_jump,
    output op_kind_e          kind,
    output logic [2:0]        sel
);
    logic top_zero;
    assign top_zero = (opcode[7:6] == 2'b00);

    always_comb begin
        known   = 1'b1;
        is_jump = 1'b0;
        kind    = KIND_NOP;
        sel     = 3'd0;
        if (opcode == OPC_NOP) begin
            kind = KIND_NOP;
        end else if (top_zero && opcode[2:0] == 3'b100) begin
            kind = KIND_INC;
            sel  = opcode[5:3];
        end else if (top_zero && opcode[2:0] == 3'b101) begin
            kind = KIND_DEC;
            sel  = opcode[5:3];
        end else if (opcode == OPC_JP) begin
            kind    = KIND_JP;
            is_jump = 1'b1;
        end else if (opcode == OPC_JPNZ) begin
            kind    = KIND_JPNZ;
            is_jump = 1'b1;
        end else begin
            known = 1'b0;
        end
    end
endmodule

// File: rtl/opdec_outslot.sv
module opdec_outslot
    import opdec_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load,
    input  op_rec_t rec_in,
    input  logic    take,
    output logic    valid,
    output op_rec_t rec
);
    typedef struct packed {
        logic    valid;
        op_rec_t rec;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (slot_q.valid && take) begin
            slot_d.valid = 1'b0;
        end
        if (load) begin
            slot_d.valid = 1'b1;
            slot_d.rec   = rec_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign valid = slot_q.valid;
    assign rec   = slot_q.rec;

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && !take) |=> (valid && $stable(rec)));

    // R7
    no_spurious_rec_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(valid) |-> $past(load));
endmodule

// File: rtl/opcode_stream_decoder.sv
module opcode_stream_decoder
    import opdec_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    output logic        in_ready,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [2:0]  out_kind,
    output logic [2:0]  out_reg,
    output logic [15:0] out_addr,
    output logic [1:0]  out_len,
    output logic        err_pulse,
    output logic [7:0]  err_opcode
);
    typedef struct packed {
        dec_state_e        state;
        op_kind_e          jkind;
        logic [BYTE_W-1:0] lo;
        logic              err;
        logic [BYTE_W-1:0] err_op;
    } core_t;

    core_t   core_d, core_q;
    logic    accept;
    logic    c_known, c_jump;
    op_kind_e c_kind;
    logic [2:0] c_sel;
    logic    rec_load;
    op_rec_t rec_new, rec_out;
    logic    slot_valid;

    opdec_classify u_classify (
        .opcode  (in_data),
        .known   (c_known),
        .is_jump (c_jump),
        .kind    (c_kind),
        .sel     (c_sel)
    );

    assign in_ready = !slot_valid;
    assign accept   = in_valid && in_ready;

    always_comb begin
        core_d     = core_q;
        core_d.err = 1'b0;
        rec_load   = 1'b0;
        rec_new    = '0;
        if (accept) begin
            unique case (core_q.state)
                ST_OPCODE: begin
                    if (!c_known) begin
                        core_d.err    = 1'b1;
                        core_d.err_op = in_data;
                    end else if (c_jump) begin
                        core_d.jkind = c_kind;
                        core_d.state = ST_LOW;
                    end else begin
                        rec_load     = 1'b1;
                        rec_new.kind = c_kind;
                        rec_new.sel  = c_sel;
                        rec_new.len  = 2'd1;
                    end
                end
                ST_LOW: begin
                    core_d.lo    = in_data;
                    core_d.state = ST_HIGH;
                end
                ST_HIGH: begin
                    rec_load     = 1'b1;
                    rec_new.kind = core_q.jkind;
                    rec_new.addr = {in_data, core_q.lo};
                    rec_new.len  = 2'd3;
                    core_d.state = ST_OPCODE;
                end
                default: core_d.state = ST_OPCODE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            core_q <= '{state: ST_OPCODE, jkind: KIND_NOP, lo: '0, err: 1'b0, err_op: '0};
        end else begin
            core_q <= core_d;
        end
    end

    opdec_outslot u_slot (
        .clk    (clk),
        .rst    (rst),
        .load   (rec_load),
        .rec_in (rec_new),
        .take   (out_ready),
        .valid  (slot_valid),
        .rec    (rec_out)
    );

    assign out_valid  = slot_valid;
    assign out_kind   = rec_out.kind;
    assign out_reg    = rec_out.sel;
    assign out_addr   = rec_out.addr;
    assign out_len    = rec_out.len;
    assign err_pulse  = core_q.err;
    assign err_opcode = core_q.err_op;

    // R8
    err_from_opcode_chk: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> ($past(accept) && $past(core_q.state) == ST_OPCODE));

    // R5
    long_is_jump_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_len == 2'd3) |-> (out_kind == KIND_JP || out_kind == KIND_JPNZ));

    // R2
    short_not_jump_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_len == 2'd1) |-> (out_kind <= KIND_DEC && out_addr == '0));

    // R10
    operand_no_err_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && core_q.state != ST_OPCODE) |=> !err_pulse);
endmodule

// File: tb/opcode_stream_decoder_bench.sv
module opcode_stream_decoder_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic in_ready;
    logic out_valid;
    logic out_ready = 1'b0;
    logic [2:0] out_kind, out_reg;
    logic [15:0] out_addr;
    logic [1:0] out_len;
    logic err_pulse;
    logic [7:0] err_opcode;

    int checks = 0;
    int errors = 0;
    logic finished = 1'b0;

    always #5 clk = ~clk;

    opcode_stream_decoder u_opcode_stream_decoder (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
        .out_kind(out_kind), .out_reg(out_reg), .out_addr(out_addr),
        .out_len(out_len), .err_pulse(err_pulse), .err_opcode(err_opcode)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send(logic [7:0] b);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic pop;
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic expect_rec(string req, int kind, int sel, int addr, int len);
        check({req, " valid"}, out_valid, 1);
        check({req, " kind"}, out_kind, kind);
        check({req, " reg"}, out_reg, sel);
        check({req, " addr"}, out_addr, addr);
        check({req, " len"}, out_len, len);
        check({req, " err"}, err_pulse, 0);
        pop();
        check({req, " cleared"}, out_valid, 0);
    endtask

    task automatic t_reset;
        check("R1 valid", out_valid, 0);
        check("R1 err", err_pulse, 0);
        check("R1 ready", in_ready, 1);
    endtask

    task automatic t_nop;
        send(8'h00);
        expect_rec("R2", 0, 0, 0, 1);
    endtask

    task automatic t_incdec;
        for (int r = 0; r < 8; r++) begin
            send(8'(r << 3) | 8'h04);
            expect_rec("R3", 1, r, 0, 1);
            send(8'(r << 3) | 8'h05);
            expect_rec("R4", 2, r, 0, 1);
        end
    endtask

    task automatic t_jumps;
        send(8'hC3);
        check("R7 no rec after opcode", out_valid, 0);
        send(8'h34);
        check("R7 no rec after low", out_valid, 0);
        send(8'h12);
        expect_rec("R5", 4, 0, 16'h1234, 3);
        send(8'hC2);
        send(8'hCD);
        send(8'hAB);
        expect_rec("R6", 3, 0, 16'hABCD, 3);
    endtask

    task automatic t_operand_bytes;
        send(8'hC3);
        send(8'hFF);
        check("R10 no err low", err_pulse, 0);
        send(8'h04);
        check("R10 no err high", err_pulse, 0);
        check("R10 no early rec", out_valid, 1);
        expect_rec("R10", 4, 0, 16'h04FF, 3);
    endtask

    task automatic t_bad;
        send(8'hFF);
        check("R8 err", err_pulse, 1);
        check("R8 opcode", err_opcode, 8'hFF);
        check("R8 no rec", out_valid, 0);
        @(negedge clk);
        check("R8 pulse ends", err_pulse, 0);
        send(8'h06);
        check("R8 err 06", err_pulse, 1);
        check("R8 opcode 06", err_opcode, 8'h06);
        send(8'h0C);
        expect_rec("R8 next opcode", 1, 1, 0, 1);
    endtask

    task automatic t_stall;
        send(8'h3D);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R9 held valid", out_valid, 1);
            check("R9 held kind", out_kind, 2);
            check("R9 held reg", out_reg, 7);
            check("R9 ready low", in_ready, 0);
        end
        in_valid = 1'b1;
        in_data  = 8'h00;
        @(negedge clk);
        in_valid = 1'b0;
        check("R9 byte ignored", out_kind, 2);
        pop();
        check("R9 cleared", out_valid, 0);
        check("R9 ready back", in_ready, 1);
    endtask

    task automatic t_reset_mid;
        send(8'hC3);
        send(8'h55);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        send(8'h24);
        expect_rec("R1 fresh opcode", 1, 4, 0, 1);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst = 1'b0;
                @(negedge clk);
                t_reset();
                t_nop();
                t_incdec();
                t_jumps();
                t_operand_bytes();
                t_bad();
                t_stall();
                t_reset_mid();
                finished = 1'b1;
            end
            begin
                repeat (20000) @(negedge clk);
                if (!finished) begin
                    checks++;
                    errors++;
                    $display("FAIL watchdog: actual hung expected done");
                end
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule